// File: doc/BRIEF.md
# HDLC Receive Idle and Frame Length Monitor

This block watches the received bit stream of one HDLC channel and raises status events. It groups the valid bits into 16-bit words and compares each word against the idle word. It reports a line that turns idle once, and it reports the line leaving idle once. It does not repeat either report while the line stays in that state.

In parallel, it counts the bytes of each frame, using the frame-start, frame-end and byte strobes of an upstream deframer. When the count passes a programmable limit, it pulses a violation event at once. It then holds a discard signal so that downstream logic drops the rest of that frame. A limit of zero turns the length check off.

Top module: `hdlc_rx_idle_len_mon`

## Requirements
- R1: Each group of 16 consecutive valid bits (`bit_vld` high), counted from reset, forms one word. The first bit of the group is the word's MSB. Words are compared only at these boundaries, and bits with `bit_vld` low are ignored.
- R2: A word equal to 0xFFFE, seen while the line state is non-idle, makes `idle_evt` pulse for exactly one cycle. The pulse comes in the cycle after the word's last bit, and the line state becomes idle.
- R3: Further 0xFFFE words while the line state is idle produce no `idle_evt`.
- R4: A word other than 0xFFFE, seen while the line state is idle, makes `nonidle_evt` pulse for one cycle in the cycle after its last bit, and the line state becomes non-idle. Further non-idle words produce nothing.
- R5: After reset the line state is non-idle. Non-idle words before the first idle word produce no `nonidle_evt`.
- R6: A frame runs from a `frm_start` cycle up to and including its `frm_end` cycle. When a counted `byte_stb` brings the frame's byte count above `max_len`, `maxlen_evt` pulses for one cycle in the next cycle.
- R7: `discard` rises together with `maxlen_evt` and stays high until the cycle after the next `frm_start`. While `discard` is high, no further byte is counted and no further `maxlen_evt` is raised.
- R8: `frm_start` clears the byte count and `discard`. A `byte_stb` in the same cycle counts as the new frame's first byte.
- R9: When `max_len` is 0, `maxlen_evt` and `discard` never rise.
- R10: A `byte_stb` outside a frame is not counted.
- R11: During reset and immediately after it, all four outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_vld | input | 1 | Qualifies `bit_in` |
| bit_in | input | 1 | Received serial bit |
| frm_start | input | 1 | Start of a frame, one cycle |
| frm_end | input | 1 | End of a frame, one cycle |
| byte_stb | input | 1 | One received byte |
| max_len | input | 16 | Maximum bytes per frame, 0 disables |
| idle_evt | output | 1 | Line became idle |
| nonidle_evt | output | 1 | Line left idle |
| maxlen_evt | output | 1 | Frame length limit exceeded |
| discard | output | 1 | Drop the rest of the current frame |

## Verification
The assertions check these rules on every cycle:
- The two line events never fire together, and they strictly alternate.
- Each line event follows a valid bit.
- A violation always comes with `discard`. `discard` persists until a frame start, and a zero limit never yields a violation.

Only the bench's scenarios can show the following:
- Word alignment and bit order, including an idle word that straddles two words and must not fire.
- That bytes outside a frame are ignored.
- The exact byte at which the violation lands.

The bench shows these by comparing against its reference model every cycle.

// File: rtl/hdlc_rx_idle_len_mon.sv
module hdlc_rx_idle_len_mon #(
  parameter int WORD_W = 16,
  parameter logic [WORD_W-1:0] IDLE_WORD = 16'hFFFE,
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_vld,
  input  logic             bit_in,
  input  logic             frm_start,
  input  logic             frm_end,
  input  logic             byte_stb,
  input  logic [LEN_W-1:0] max_len,
  output logic             idle_evt,
  output logic             nonidle_evt,
  output logic             maxlen_evt,
  output logic             discard
);
  localparam int PH_W  = $clog2(WORD_W);
  localparam int CNT_W = LEN_W + 1;

  logic [WORD_W-1:0] win;
  logic [PH_W-1:0]   phase;
  logic              line_idle;

  wire [WORD_W-1:0] win_nx    = {win[WORD_W-2:0], bit_in};
  wire              word_done = bit_vld && (phase == PH_W'(WORD_W - 1));
  wire              is_idle   = (win_nx == IDLE_WORD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win         <= '0;
      phase       <= '0;
      line_idle   <= 1'b0;
      idle_evt    <= 1'b0;
      nonidle_evt <= 1'b0;
    end else begin
      idle_evt    <= 1'b0;
      nonidle_evt <= 1'b0;
      if (bit_vld) begin
        win   <= win_nx;
        phase <= word_done ? '0 : phase + 1'b1;
      end
      if (word_done) begin
        if (is_idle && !line_idle) begin
          idle_evt  <= 1'b1;
          line_idle <= 1'b1;
        end else if (!is_idle && line_idle) begin
          nonidle_evt <= 1'b1;
          line_idle   <= 1'b0;
        end
      end
    end
  end

  logic [CNT_W-1:0] cnt;
  logic             in_frame;

  wire              counting  = frm_start | in_frame;
  wire [CNT_W-1:0]  cnt_base  = frm_start ? '0 : cnt;
  wire              disc_base = frm_start ? 1'b0 : discard;
  wire              take      = byte_stb && counting && !disc_base;
  wire [CNT_W-1:0]  cnt_nx    = cnt_base + CNT_W'(take);
  wire              over      = take && (max_len != '0) && (cnt_nx > {1'b0, max_len});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= '0;
      in_frame   <= 1'b0;
      discard    <= 1'b0;
      maxlen_evt <= 1'b0;
    end else begin
      cnt        <= cnt_nx;
      discard    <= disc_base | over;
      maxlen_evt <= over;
      in_frame   <= frm_start | (in_frame & ~frm_end);
    end
  end
endmodule

module hdlc_rx_idle_len_mon_chk #(
  parameter int LEN_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bit_vld,
  input logic             frm_start,
  input logic             byte_stb,
  input logic [LEN_W-1:0] max_len,
  input logic             idle_evt,
  input logic             nonidle_evt,
  input logic             maxlen_evt,
  input logic             discard
);
  logic seen_idle;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_idle <= 1'b0;
    else if (idle_evt) seen_idle <= 1'b1;
    else if (nonidle_evt) seen_idle <= 1'b0;
  end

  p_evt_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(idle_evt && nonidle_evt));
  p_idle_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
    idle_evt |-> !seen_idle);
  p_nonidle_after_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    nonidle_evt |-> seen_idle);
  p_evt_on_bit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_evt || nonidle_evt) |-> $past(bit_vld));
  p_viol_discard_r7: assert property (@(posedge clk) disable iff (!rst_n)
    maxlen_evt |-> discard);
  p_discard_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (discard && !frm_start) |=> discard);
  p_viol_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    maxlen_evt |=> !maxlen_evt);
  p_viol_enabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
    maxlen_evt |-> $past(max_len != '0 && byte_stb));
  p_start_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_start && !byte_stb) |=> !discard);
endmodule

bind hdlc_rx_idle_len_mon hdlc_rx_idle_len_mon_chk #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .frm_start(frm_start),
  .byte_stb(byte_stb), .max_len(max_len), .idle_evt(idle_evt),
  .nonidle_evt(nonidle_evt), .maxlen_evt(maxlen_evt), .discard(discard)
);

// File: tb/tb_hdlc_rx_idle_len_mon.sv
module tb_hdlc_rx_idle_len_mon;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bit_vld = 0, bit_in = 0, frm_start = 0, frm_end = 0, byte_stb = 0;
  logic [15:0] max_len = '0;
  logic idle_evt, nonidle_evt, maxlen_evt, discard;

  hdlc_rx_idle_len_mon dut (.*);

  always #2 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  int n_idle = 0, n_non = 0, n_max = 0;
  bit done = 0;

  // behavioural reference
  int  m_win, m_ph, m_cnt;
  bit  m_idle_st, m_inf, m_disc;
  bit  e_idle, e_non, e_max;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_win = 0; m_ph = 0; m_cnt = 0; m_idle_st = 0; m_inf = 0; m_disc = 0;
      e_idle = 0; e_non = 0; e_max = 0;
    end else begin
      bit cnt_ok;
      e_idle = 0; e_non = 0; e_max = 0;
      if (bit_vld) begin
        m_win = ((m_win << 1) | int'(bit_in)) & 'hFFFF;
        m_ph++;
        if (m_ph == 16) begin
          m_ph = 0;
          if (m_win == 'hFFFE && !m_idle_st) begin e_idle = 1; m_idle_st = 1; end
          else if (m_win != 'hFFFE && m_idle_st) begin e_non = 1; m_idle_st = 0; end
        end
      end
      cnt_ok = frm_start || m_inf;
      if (frm_start) begin m_cnt = 0; m_disc = 0; end
      if (byte_stb && cnt_ok && !m_disc) begin
        m_cnt++;
        if (max_len != 0 && m_cnt > int'(max_len)) begin e_max = 1; m_disc = 1; end
      end
      if (frm_start) m_inf = 1;
      else if (frm_end) m_inf = 0;
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      chk("R2 R3 idle_evt", idle_evt, e_idle);
      chk("R4 R5 nonidle_evt", nonidle_evt, e_non);
      chk("R6 maxlen_evt", maxlen_evt, e_max);
      chk("R7 discard", discard, m_disc);
      n_idle += int'(idle_evt); n_non += int'(nonidle_evt); n_max += int'(maxlen_evt);
    end
  end

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic send_word(logic [15:0] w, bit gaps);
    for (int i = 15; i >= 0; i--) begin
      bit_vld = 1; bit_in = w[i]; tick();
      if (gaps && i[0]) begin bit_vld = 0; bit_in = ~w[i]; tick(); end
    end
    bit_vld = 0; bit_in = 0;
  endtask

  task automatic start(bit with_byte);
    frm_start = 1; byte_stb = with_byte; tick(); frm_start = 0; byte_stb = 0;
  endtask

  task automatic bytes(int n);
    for (int i = 0; i < n; i++) begin byte_stb = 1; tick(); byte_stb = 0; tick(); end
  endtask

  task automatic finish_frame();
    frm_end = 1; tick(); frm_end = 0; tick();
  endtask

  initial begin
    int b;
    tick(); tick();
    chk("R11 reset idle_evt", idle_evt, 0);
    chk("R11 reset discard", discard, 0);
    rst_n = 1; tick();
    chk("R11 after reset maxlen_evt", maxlen_evt, 0);
    chk("R11 after reset nonidle_evt", nonidle_evt, 0);

    b = n_idle;
    send_word(16'h7FFF, 1); send_word(16'h1234, 0); tick();
    chk("R5 no nonidle before first idle", n_non, 0);
    chk("R1 MSB-first order, 0x7FFF not idle", n_idle - b, 0);
    send_word(16'h00FF, 0); send_word(16'hFE00, 1); tick();
    chk("R1 straddling idle word ignored", n_idle - b, 0);
    send_word(16'hFFFE, 1); tick();
    chk("R2 idle word raises idle_evt", n_idle - b, 1);
    send_word(16'hFFFE, 0); send_word(16'hFFFE, 1); tick();
    chk("R3 repeated idle silent", n_idle - b, 1);
    b = n_non;
    send_word(16'hABCD, 0); tick();
    chk("R4 non-idle after idle", n_non - b, 1);
    send_word(16'h0000, 1); tick();
    chk("R4 second non-idle silent", n_non - b, 1);
    send_word(16'hFFFE, 0); tick();
    chk("R2 idle again after non-idle", n_idle, 2);

    max_len = 16'd5;
    b = n_max;
    start(0); bytes(5); finish_frame();
    chk("R6 exactly max bytes no violation", n_max - b, 0);
    start(0); bytes(8); tick();
    chk("R6 violation on byte six", n_max - b, 1);
    chk("R7 discard held", discard, 1);
    finish_frame();
    chk("R7 discard held past frame end", discard, 1);
    start(1); tick();
    chk("R8 start clears discard", discard, 0);
    bytes(4); finish_frame();
    chk("R8 start byte counted, 5 total ok", n_max - b, 1);
    start(1); bytes(5); finish_frame();
    chk("R8 start byte counted, 6 total violates", n_max - b, 2);

    max_len = 16'd3;
    start(0); bytes(2); frm_end = 1; byte_stb = 1; tick(); frm_end = 0; byte_stb = 0; tick();
    bytes(6);
    chk("R10 bytes outside frame ignored", n_max - b, 2);
    start(0); bytes(3); frm_end = 1; byte_stb = 1; tick(); frm_end = 0; byte_stb = 0; tick();
    chk("R6 byte on end cycle counted", n_max - b, 3);

    max_len = 16'd0;
    start(1); bytes(300); finish_frame();
    chk("R9 zero limit disables", n_max - b, 3);
    chk("R9 zero limit no discard", discard, 0);

    tick(); tick();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      done = 1; n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule